// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block is the read data path on the memory side of a single-data-rate SDRAM. A READ command carries a bank and a starting column. The block fetches the matching words from a small internal word array. It places them on a tri-statable data bus a programmable number of clock cycles after the command. This delay is the CAS latency. The bus stays in high impedance whenever no word is due.

A single issue point produces at most one word address per clock. These addresses then pass through a fixed delay line whose length is set by the CAS latency. Because every word sees the same delay, a READ that arrives during a running burst cuts that burst cleanly. The new data follows the last wanted word with no gap at every latency. Fixed bursts wrap inside an aligned block of their own length. Full-page bursts wrap around the page and continue until a terminate pulse or a new READ stops them.

The latency and burst length are static inputs. They are captured only while the data path is quiet. A backdoor write port loads the word array, so a checker can predict every returned word.

Top module: `sdram_rd_pipe`

## Requirements
- R1: A READ sampled at clock edge k drives its first word from edge k+CL-1 until edge k+CL. CL is the captured `cas_lat` value (1, 2 or 3; the code 0 acts as 1). Each later word of the burst follows one cycle after the one before it.
- R2: `dq_oe` is low, and `dq` is released, on every cycle where no burst word is due. After the last word of a burst, the bus is released on the next cycle unless another READ supplies data for that cycle.
- R3: `burst_sel` codes 0, 1, 2 and 3 give fixed bursts of 1, 2, 4 and 8 words.
- R4: Within a fixed burst of length L that starts at column s, word i comes from column (s with its low log2(L) bits cleared) + ((s + i) mod L). The bank stays the same for the whole burst.
- R5: `burst_sel` code 7 selects a full-page burst. Column 255 is followed by column 0, and the burst keeps going. A `cmd_term` pulse at edge t stops it: the last word delivered is the one issued at edge t-1. A READ at the same edge takes priority over `cmd_term`.
- R6: A READ that arrives while a burst is still issuing words truncates that burst. The new burst's first word occupies the bus on the cycle directly after the last word issued before the READ edge.
- R7: A READ may be issued on any clock, to any bank. A READ issued on the edge right after a fixed burst's last word keeps the data stream continuous. READs on consecutive edges each return one word per cycle.
- R8: `cas_lat` and `burst_sel` are captured only on edges where no burst is issuing, no word is in flight and no READ is present. A READ uses the values captured on the last such edge, so changes made during a burst have no effect until the path is idle.
- R9: A backdoor write to bank b, column c sets the word that later READs return for that location.
- R10: After synchronous reset, `dq_oe` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_read | input | 1 | READ command strobe |
| cmd_term | input | 1 | Stops a running burst |
| cmd_bank | input | 2 | Bank of the READ |
| cmd_col | input | 8 | Starting column of the READ |
| cas_lat | input | 2 | CAS latency in cycles (1 to 3) |
| burst_sel | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| bd_we | input | 1 | Backdoor array write enable |
| bd_bank | input | 2 | Backdoor write bank |
| bd_col | input | 8 | Backdoor write column |
| bd_data | input | 32 | Backdoor write data |
| dq_data | output | 32 | Registered read word |
| dq_oe | output | 1 | Bus drive enable, high while a word is valid |
| dq | inout | 32 | Tri-state data bus |

## Verification
The latency assertions rely on the captured CAS latency staying fixed from the moment a word is issued until that word reaches the output. That holds only because the configuration freeze of R8 covers every word in flight. They also require `cas_lat` to be no larger than the delay line built for it. The stimulus uses only the legal latency and burst codes, and it drives all inputs on the falling clock edge. Except in the one deliberate mid-burst change for R8, it alters the configuration only after at least six quiet cycles. Backdoor writes never overlap a read of the same location.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [2:0] {
    BURST_1    = 3'd0,
    BURST_2    = 3'd1,
    BURST_4    = 3'd2,
    BURST_8    = 3'd3,
    BURST_PAGE = 3'd7
  } burst_sel_e;

  // words per fixed burst; 0 stands for a full page
  function automatic int unsigned burst_words(input logic [2:0] sel);
    case (sel)
      BURST_2:    return 2;
      BURST_4:    return 4;
      BURST_8:    return 8;
      BURST_PAGE: return 0;
      default:    return 1;
    endcase
  endfunction

endpackage

// File: rtl/srp_word_array.sv
module srp_word_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read port, doubles as the bus data register
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/srp_burst_gen.sv
module srp_burst_gen #(
  parameter int BW = 2,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          term,
  input  logic [BW-1:0] rd_bank,
  input  logic [CW-1:0] rd_col,
  input  logic [CW-1:0] cfg_mask,
  input  logic          cfg_page,
  output logic          iss_v,
  output logic [BW-1:0] iss_bank,
  output logic [CW-1:0] iss_col,
  output logic          busy
);

  logic          act_q;
  logic          page_q;
  logic [BW-1:0] bank_q;
  logic [CW-1:0] col_q;
  logic [CW-1:0] left_q;
  logic [CW-1:0] nxt_col;

  // one word address per clock; a new READ always overrides
  always_comb begin
    iss_v    = 1'b0;
    iss_bank = bank_q;
    iss_col  = col_q;
    if (rd) begin
      iss_v    = 1'b1;
      iss_bank = rd_bank;
      iss_col  = rd_col;
    end else if (act_q && !term) begin
      iss_v = 1'b1;
    end
  end

  // increment inside the aligned block given by the mask
  assign nxt_col = (iss_col & ~cfg_mask) | ((iss_col + CW'(1)) & cfg_mask);
  assign busy    = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      page_q <= 1'b0;
      left_q <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (rd) begin
      bank_q <= rd_bank;
      col_q  <= nxt_col;
      page_q <= cfg_page;
      left_q <= cfg_mask;
      act_q  <= cfg_page || (cfg_mask != '0);
    end else if (term) begin
      act_q  <= 1'b0;
      page_q <= 1'b0;
    end else if (act_q) begin
      col_q <= nxt_col;
      if (!page_q) begin
        left_q <= left_q - CW'(1);
        if (left_q == CW'(1)) act_q <= 1'b0;
      end
    end
  end

  // R4: continuation words stay inside the aligned block of the burst
  p_block_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (act_q && !rd && !term && !page_q) |=>
      ((col_q & ~cfg_mask) == $past(col_q & ~cfg_mask)));

  // R5: a page burst keeps issuing until stopped
  p_page_runs_r5: assert property (@(posedge clk) disable iff (rst)
    (act_q && page_q && !term) |=> act_q);

endmodule

// File: rtl/srp_lat_pipe.sv
module srp_lat_pipe #(
  parameter int AW    = 10,
  parameter int MAXCL = 3,
  localparam int CLW  = $clog2(MAXCL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CLW-1:0] cl,
  input  logic           iss_v,
  input  logic [AW-1:0]  iss_addr,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           oe,
  output logic           pend
);

  logic [MAXCL-1:1]         v_q;
  logic [MAXCL-1:1][AW-1:0] a_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      v_q[1] <= iss_v;
      for (int k = 2; k < MAXCL; k++) v_q[k] <= v_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    a_q[1] <= iss_addr;
    for (int k = 2; k < MAXCL; k++) a_q[k] <= a_q[k-1];
  end

  // tap chosen by latency: CL=1 reads straight from the issue point
  always_comb begin
    rd_en   = iss_v;
    rd_addr = iss_addr;
    for (int k = 1; k < MAXCL; k++) begin
      if (cl == CLW'(k + 1)) begin
        rd_en   = v_q[k];
        rd_addr = a_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= rd_en;
  end

  assign pend = |v_q;

  // R1: an issued word reaches the bus after exactly CL edges
  p_lat1_r1: assert property (@(posedge clk) disable iff (rst)
    (iss_v && cl == CLW'(1)) |=> oe);
  p_lat2_r1: assert property (@(posedge clk) disable iff (rst)
    (iss_v && cl == CLW'(2)) |=> ##1 oe);
  p_lat3_r1: assert property (@(posedge clk) disable iff (rst)
    (iss_v && cl == CLW'(3)) |=> ##2 oe);

  // R2: nothing issued and nothing in flight means the bus is released
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!iss_v && !pend) |=> !oe);

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int BANKS = 4,
  parameter int COLS  = 256,
  parameter int DW    = 32,
  parameter int MAXCL = 3,
  localparam int BW   = $clog2(BANKS),
  localparam int CW   = $clog2(COLS),
  localparam int AW   = BW + CW,
  localparam int CLW  = $clog2(MAXCL + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_read,
  input  logic           cmd_term,
  input  logic [BW-1:0]  cmd_bank,
  input  logic [CW-1:0]  cmd_col,
  input  logic [CLW-1:0] cas_lat,
  input  logic [2:0]     burst_sel,
  input  logic           bd_we,
  input  logic [BW-1:0]  bd_bank,
  input  logic [CW-1:0]  bd_col,
  input  logic [DW-1:0]  bd_data,
  output logic [DW-1:0]  dq_data,
  output logic           dq_oe,
  inout  wire  [DW-1:0]  dq
);
  import sdram_rd_pkg::*;

  logic [CLW-1:0] cl_q;
  logic [CW-1:0]  mask_q;
  logic           page_q;
  logic [CW-1:0]  mask_d;
  logic           cfg_open;
  int unsigned    words_d;

  logic          iss_v;
  logic [BW-1:0] iss_bank;
  logic [CW-1:0] iss_col;
  logic          busy;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          pend;

  always_comb begin
    words_d = burst_words(burst_sel);
    mask_d  = (words_d == 0) ? '1 : CW'(words_d - 1);
  end

  // capture configuration only while the path is quiet
  assign cfg_open = !busy && !cmd_read && !pend && !dq_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q   <= CLW'(1);
      mask_q <= '0;
      page_q <= 1'b0;
    end else if (cfg_open) begin
      cl_q   <= (cas_lat == '0) ? CLW'(1) : cas_lat;
      mask_q <= mask_d;
      page_q <= (words_d == 0);
    end
  end

  srp_burst_gen #(.BW(BW), .CW(CW)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .rd       (cmd_read),
    .term     (cmd_term),
    .rd_bank  (cmd_bank),
    .rd_col   (cmd_col),
    .cfg_mask (mask_q),
    .cfg_page (page_q),
    .iss_v    (iss_v),
    .iss_bank (iss_bank),
    .iss_col  (iss_col),
    .busy     (busy)
  );

  srp_lat_pipe #(.AW(AW), .MAXCL(MAXCL)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .cl       (cl_q),
    .iss_v    (iss_v),
    .iss_addr ({iss_bank, iss_col}),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .oe       (dq_oe),
    .pend     (pend)
  );

  srp_word_array #(.DW(DW), .DEPTH(BANKS * COLS)) u_array (
    .clk     (clk),
    .wr_en   (bd_we),
    .wr_addr ({bd_bank, bd_col}),
    .wr_data (bd_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (dq_data)
  );

  assign dq = dq_oe ? dq_data : {DW{1'bz}};

  // R8: configuration held while a burst issues or a word is driven
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy || dq_oe) |=> ($stable(cl_q) && $stable(mask_q) && $stable(page_q)));

  // R10: the cycle after reset leaves no burst active
  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (!busy && !dq_oe));

endmodule

// File: tb/sdram_rd_pipe_tb_top.sv
module sdram_rd_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_read = 1'b0, cmd_term = 1'b0;
  logic [1:0]  cmd_bank = '0;
  logic [7:0]  cmd_col = '0;
  logic [1:0]  cas_lat = 2'd1;
  logic [2:0]  burst_sel = 3'd0;
  logic        bd_we = 1'b0;
  logic [1:0]  bd_bank = '0;
  logic [7:0]  bd_col = '0;
  logic [31:0] bd_data = '0;
  logic [31:0] dq_data;
  logic        dq_oe;
  wire  [31:0] dq;

  always #5 clk = ~clk;

  sdram_rd_pipe dut_i (
    .clk(clk), .rst(rst), .cmd_read(cmd_read), .cmd_term(cmd_term),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cas_lat(cas_lat),
    .burst_sel(burst_sel), .bd_we(bd_we), .bd_bank(bd_bank),
    .bd_col(bd_col), .bd_data(bd_data), .dq_data(dq_data),
    .dq_oe(dq_oe), .dq(dq)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string tag = "R10";

  // behavioural reference model
  logic [31:0] mm [0:1023];
  bit          exp_v [16];
  logic [31:0] exp_d [16];
  int m_cl = 1, m_mask = 0, m_left = 0, m_start = 0, m_i = 0, m_bank = 0;
  bit m_pg = 0, m_full = 0;
  bit [2:0] hist = '0;

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit iv;
    int b, c;
    iv = 0; b = 0; c = 0;
    if (rst) begin
      m_left = 0; m_full = 0; hist = '0; m_cl = 1; m_mask = 0; m_pg = 0;
      for (int k = 0; k < 16; k++) exp_v[k] = 0;
    end else begin
      if (!cmd_read && m_left == 0 && !m_full && hist == 3'b000) begin
        m_cl = (cas_lat == 2'd0) ? 1 : int'(cas_lat);
        m_pg = (burst_sel == 3'd7);
        case (burst_sel)
          3'd1: m_mask = 1;
          3'd2: m_mask = 3;
          3'd3: m_mask = 7;
          3'd7: m_mask = 255;
          default: m_mask = 0;
        endcase
      end
      if (cmd_read) begin
        iv = 1; b = int'(cmd_bank); c = int'(cmd_col);
        m_bank = b; m_start = c; m_i = 1; m_full = m_pg;
        m_left = m_pg ? 0 : m_mask;
      end else if (cmd_term) begin
        m_left = 0; m_full = 0;
      end else if (m_full || m_left > 0) begin
        iv = 1; b = m_bank;
        c = (m_start & ~m_mask & 255) | ((m_start + m_i) & m_mask);
        m_i++;
        if (!m_full) m_left--;
      end
      hist = {hist[1:0], iv};
      exp_v[(cyc + m_cl - 1) % 16] = iv;
      if (iv) exp_d[(cyc + m_cl - 1) % 16] = mm[b * 256 + c];
    end
    cyc++;
  end

  always @(negedge clk) begin : compare
    int idx;
    if (!rst && cyc > 0 && !done) begin
      idx = (cyc - 1) % 16;
      chk(dq_oe == exp_v[idx], "dq_oe", {31'd0, dq_oe}, {31'd0, exp_v[idx]});
      if (exp_v[idx]) begin
        chk(dq_data == exp_d[idx], "dq_data", dq_data, exp_d[idx]);
        chk(dq === exp_d[idx], "dq bus", dq, exp_d[idx]);
      end
      exp_v[idx] = 0;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int cl, input logic [2:0] sel);
    @(negedge clk);
    cas_lat = 2'(cl);
    burst_sel = sel;
  endtask

  task automatic rd(input int b, input int c);
    @(negedge clk);
    cmd_read = 1'b1; cmd_bank = 2'(b); cmd_col = 8'(c);
    @(negedge clk);
    cmd_read = 1'b0;
  endtask

  task automatic bd_write(input int b, input int c, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_bank = 2'(b); bd_col = 8'(c); bd_data = d;
    mm[b * 256 + c] = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    tag = "R10";
    chk(dq_oe == 1'b0, "oe in reset", {31'd0, dq_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(dq_oe == 1'b0, "oe after reset", {31'd0, dq_oe}, 32'd0);

    tag = "R9";
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 256; c++)
        bd_write(b, c, 32'h5A00_0000 ^ (32'(b) << 20) ^ (32'(c) * 32'h0001_0103));

    // R1 R2 R3 R4: every latency with every fixed length
    tag = "R1/R2/R3/R4";
    for (int cl = 1; cl <= 3; cl++)
      for (int s = 0; s < 4; s++) begin
        set_cfg(cl, 3'(s));
        idle(6);
        rd(cl, 8'h3D + s * 17);
        idle(14);
      end
    set_cfg(0, 3'd2);
    idle(6);
    rd(2, 8'hFE);
    idle(12);

    // R5: full page crossing the page end, then stopped
    tag = "R5";
    for (int cl = 2; cl <= 3; cl++) begin
      set_cfg(cl, 3'd7);
      idle(6);
      rd(1, 250);
      idle(11);
      @(negedge clk); cmd_term = 1'b1;
      @(negedge clk); cmd_term = 1'b0;
      idle(8);
    end

    // R6: truncation of a running burst at every latency
    tag = "R6";
    for (int cl = 1; cl <= 3; cl++) begin
      set_cfg(cl, 3'd3);
      idle(6);
      rd(0, 5);
      idle(2);
      rd(2, 8'h80);
      idle(14);
    end
    set_cfg(1, 3'd7);
    idle(6);
    rd(3, 40);
    idle(5);
    rd(0, 200);
    idle(3);
    @(negedge clk); cmd_term = 1'b1;
    @(negedge clk); cmd_term = 1'b0;
    idle(8);

    // R7: seamless back-to-back and READs on every edge
    tag = "R7";
    set_cfg(3, 3'd2);
    idle(6);
    rd(3, 12);
    idle(2);
    rd(1, 7);
    idle(12);
    set_cfg(2, 3'd0);
    idle(6);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cmd_read = 1'b1; cmd_bank = 2'(i); cmd_col = 8'(i * 29);
    end
    @(negedge clk); cmd_read = 1'b0;
    idle(10);

    // R8: configuration changed mid-burst has no effect until idle
    tag = "R8";
    set_cfg(1, 3'd7);
    idle(6);
    rd(2, 100);
    idle(3);
    set_cfg(3, 3'd1);
    idle(5);
    @(negedge clk); cmd_term = 1'b1;
    @(negedge clk); cmd_term = 1'b0;
    idle(8);
    rd(2, 100);
    idle(10);

    // R9: backdoor rewrite is returned by a later read
    tag = "R9";
    bd_write(0, 0, 32'hC0DE_F00D);
    set_cfg(2, 3'd1);
    idle(6);
    rd(0, 1);
    idle(10);

    done = 1;
    summary();
    $finish;
  end

endmodule